// File: doc/BRIEF.md
# Selectable Double-Speed Clock-Enable Prescaler

This block turns one oscillator clock into a set of single-cycle enable pulses: one for the CPU and one each for timer 0, timer 1, the counter array and the SPI controller. Each consumer runs on the oscillator clock and advances only in cycles where its enable is high. After reset every enable pulses on alternate oscillator cycles. This is the standard rate, where a divide-by-two stage sits in front of every consumer.

Software sets a global double-speed bit to bypass the divider for the CPU, whose enable then stays high in every cycle. In that mode each peripheral has its own bit that keeps it at the halved rate (bit set) or lets it follow the fast rate (bit cleared). The peripheral bits have no effect while the global bit is clear. A change of the global bit is not applied at once. It takes effect only at a rising edge of the internal divided clock, so the CPU never sees a shortened or missing enable period.

Both settings sit in two 8-bit configuration registers. They are written through a simple write strobe and read back combinationally.

Top module: `x2_clk_prescaler`

## Requirements
- R1: While reset is asserted, and right after it, every readback is 0x00 and the block is in standard mode. In any 8 consecutive cycles after release the CPU enable is high in exactly 4.
- R2: In standard mode all five enables pulse in the same cycles, on alternate oscillator cycles. The CPU enable is never low in two consecutive cycles.
- R3: A written change of the global double-speed bit (register 0, bit 0) takes effect only at the end of a cycle in which the divided-phase pulse is high. A write that lands at the end of such a cycle shows up two cycles later, not one.
- R4: With the global bit set, the CPU enable is high in every cycle. So is each peripheral enable whose own bit is 0.
- R5: With the global bit set, a peripheral whose bit is 1 pulses only on alternate cycles, in phase with the divider. Its bits are: timer 0 at register 0 bit 1, timer 1 at register 0 bit 2, counter array at register 0 bit 5, SPI at register 1 bit 0.
- R6: While the global bit is 0 the peripheral bits have no effect, and every peripheral enable pulses at the halved rate. A peripheral enable is never high in a cycle where the CPU enable is low.
- R7: Reserved bits ignore writes and read as 0. These are register 0 bits 3, 4, 6 and 7, and register 1 bits 7 to 1. Writing 0xFF therefore reads back 0x27 in register 0 and 0x01 in register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 1 | Register select: 0 = mode/timers/array, 1 = SPI |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| cpu_tick | output | 1 | CPU enable pulse |
| tmr0_tick | output | 1 | Timer 0 enable pulse |
| tmr1_tick | output | 1 | Timer 1 enable pulse |
| arr_tick | output | 1 | Counter array enable pulse |
| spi_tick | output | 1 | SPI enable pulse |

## Verification
The hardest case to reach from the ports is the deferred mode switch. The divider phase is never output, and in double-speed mode the CPU enable no longer shows it. To switch into double speed, the stimulus waits until the CPU enable is seen high and writes the global bit in that same cycle. The expected pattern 0, 1, 1, 1 separates deferred from immediate application. To switch back, a timer is first kept at the slow rate so that its enable reveals the phase, and the expected CPU pattern is then 1, 1, 0, 1.

// File: rtl/x2pre_pkg.sv
package x2pre_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_PERIPH = 4;
  localparam int NUM_TICK   = NUM_PERIPH + 1;

  // register 0 field positions
  localparam int POS_X2  = 0;
  localparam int POS_T0  = 1;
  localparam int POS_T1  = 2;
  localparam int POS_ARR = 5;
  // register 1 field position
  localparam int POS_SPI = 0;

  // index of each consumer in the peripheral slow-select vector
  typedef enum int {
    IDX_T0  = 0,
    IDX_T1  = 1,
    IDX_ARR = 2,
    IDX_SPI = 3
  } periph_idx_e;
endpackage

// File: rtl/x2pre_phase.sv
module x2pre_phase (
  input  logic clk,
  input  logic rst_n,
  output logic slow_phase
);
  logic ph_q;
  logic ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign slow_phase = ph_q;
endmodule

// File: rtl/x2pre_mode_sync.sv
module x2pre_mode_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_phase,
  input  logic x2_req,
  output logic x2_eff
);
  logic eff_q;
  logic eff_d;

  // mode change accepted only where the divided clock rises
  always_comb begin
    eff_d = eff_q;
    if (slow_phase) eff_d = x2_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= 1'b0;
    else        eff_q <= eff_d;
  end

  assign x2_eff = eff_q;
endmodule

// File: rtl/x2pre_tick_sel.sv
module x2pre_tick_sel #(
  parameter int N = 5
) (
  input  logic         slow_phase,
  input  logic         x2_eff,
  input  logic [N-1:0] slow_sel,
  output logic [N-1:0] tick
);
  for (genvar i = 0; i < N; i++) begin : g_tick
    assign tick[i] = slow_phase | (x2_eff & ~slow_sel[i]);
  end
endmodule

// File: rtl/x2pre_regs.sv
module x2pre_regs
  import x2pre_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  addr,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic                  x2_req,
  output logic [NUM_PERIPH-1:0] per_slow
);
  logic                  x2_q, x2_d;
  logic [NUM_PERIPH-1:0] slow_q, slow_d;

  always_comb begin
    x2_d   = x2_q;
    slow_d = slow_q;
    if (wr && !addr) begin
      x2_d            = wdata[POS_X2];
      slow_d[IDX_T0]  = wdata[POS_T0];
      slow_d[IDX_T1]  = wdata[POS_T1];
      slow_d[IDX_ARR] = wdata[POS_ARR];
    end
    if (wr && addr) begin
      slow_d[IDX_SPI] = wdata[POS_SPI];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x2_q   <= 1'b0;
      slow_q <= '0;
    end else begin
      x2_q   <= x2_d;
      slow_q <= slow_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[POS_X2]  = x2_q;
      rdata[POS_T0]  = slow_q[IDX_T0];
      rdata[POS_T1]  = slow_q[IDX_T1];
      rdata[POS_ARR] = slow_q[IDX_ARR];
    end else begin
      rdata[POS_SPI] = slow_q[IDX_SPI];
    end
  end

  assign x2_req   = x2_q;
  assign per_slow = slow_q;
endmodule

// File: rtl/x2_clk_prescaler.sv
module x2_clk_prescaler
  import x2pre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             cpu_tick,
  output logic             tmr0_tick,
  output logic             tmr1_tick,
  output logic             arr_tick,
  output logic             spi_tick
);
  logic                  rst_meta_q, rst_sync_q;
  logic                  slow_phase;
  logic                  x2_req;
  logic                  x2_eff;
  logic [NUM_PERIPH-1:0] per_slow;
  logic [NUM_TICK-1:0]   slow_sel;
  logic [NUM_TICK-1:0]   tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  x2pre_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr       (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .x2_req   (x2_req),
    .per_slow (per_slow)
  );

  x2pre_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .slow_phase (slow_phase)
  );

  x2pre_mode_sync u_mode (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .slow_phase (slow_phase),
    .x2_req     (x2_req),
    .x2_eff     (x2_eff)
  );

  // index 0 is the CPU, which never selects the halved rate
  assign slow_sel = {per_slow, 1'b0};

  x2pre_tick_sel #(.N(NUM_TICK)) u_sel (
    .slow_phase (slow_phase),
    .x2_eff     (x2_eff),
    .slow_sel   (slow_sel),
    .tick       (tick)
  );

  assign cpu_tick  = tick[0];
  assign tmr0_tick = tick[1 + IDX_T0];
  assign tmr1_tick = tick[1 + IDX_T1];
  assign arr_tick  = tick[1 + IDX_ARR];
  assign spi_tick  = tick[1 + IDX_SPI];
endmodule

// File: rtl/x2_clk_prescaler_chk.sv
module x2_clk_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       cfg_addr,
  input logic [7:0] cfg_rdata,
  input logic       cpu_tick,
  input logic       tmr0_tick,
  input logic       tmr1_tick,
  input logic       arr_tick,
  input logic       spi_tick,
  input logic       slow_phase,
  input logic       x2_eff,
  input logic       t0_slow
);
  // R2: CPU enable never misses two cycles in a row, also across switches
  p_no_idle_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tick |=> cpu_tick);

  // R3: effective mode moves only after a divided-phase cycle
  p_switch_on_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (x2_eff != $past(x2_eff)) |-> $past(slow_phase));

  // R5: a slow-selected timer 0 enable never fires twice in a row
  p_slow_alternates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr0_tick && t0_slow && !cfg_wr) |=> !tmr0_tick);

  // R6: no peripheral enable outside a CPU enable
  p_periph_within_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr0_tick || tmr1_tick || arr_tick || spi_tick) |-> cpu_tick);

  // R7: reserved readback bits stay 0
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr ? (cfg_rdata[7:1] == 7'd0)
             : (cfg_rdata[7:6] == 2'd0 && cfg_rdata[4:3] == 2'd0));
endmodule

bind x2_clk_prescaler x2_clk_prescaler_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_q),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .cfg_rdata  (cfg_rdata),
  .cpu_tick   (cpu_tick),
  .tmr0_tick  (tmr0_tick),
  .tmr1_tick  (tmr1_tick),
  .arr_tick   (arr_tick),
  .spi_tick   (spi_tick),
  .slow_phase (slow_phase),
  .x2_eff     (x2_eff),
  .t0_slow    (per_slow[0])
);

// File: tb/x2_clk_prescaler_bench.sv
module x2_clk_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic       cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       cpu_tick, tmr0_tick, tmr1_tick, arr_tick, spi_tick;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  x2_clk_prescaler u_x2_clk_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cpu_tick  (cpu_tick),
    .tmr0_tick (tmr0_tick),
    .tmr1_tick (tmr1_tick),
    .arr_tick  (arr_tick),
    .spi_tick  (spi_tick)
  );

  // {reg0 write, reg1 write, reg0 expected, reg1 expected,
  //  fast mask: cpu, t0, t1, arr, spi}
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 5'b00000},
    {8'h01, 8'h00, 8'h01, 8'h00, 5'b11111},
    {8'h07, 8'h00, 8'h07, 8'h00, 5'b10011},
    {8'h21, 8'h01, 8'h21, 8'h01, 5'b11100},
    {8'h26, 8'h01, 8'h26, 8'h01, 5'b00000},
    {8'hFF, 8'hFF, 8'h27, 8'h01, 5'b10000},
    {8'hDA, 8'hFE, 8'h02, 8'h00, 5'b00000},
    {8'hD9, 8'h00, 8'h01, 8'h00, 5'b11111}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic count_ticks(output int c [5]);
    for (int k = 0; k < 5; k++) c[k] = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      c[0] += int'(cpu_tick);
      c[1] += int'(tmr0_tick);
      c[2] += int'(tmr1_tick);
      c[3] += int'(arr_tick);
      c[4] += int'(spi_tick);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int c [5];
    int exp_pat [4];
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 1'b0; cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cpu_tick in reset", int'(cpu_tick), 0);
    cfg_addr = 1'b0; #1 check("R1 reg0 in reset", int'(cfg_rdata), 0);
    cfg_addr = 1'b1; #1 check("R1 reg1 in reset", int'(cfg_rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    count_ticks(c);
    check("R1 cpu ticks after reset", c[0], 4);
    read_reg(1'b0, rd); check("R1 reg0 after reset", int'(rd), 0);

    // R2: all enables coincide in standard mode
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R2 coincident enables",
            int'({tmr0_tick, tmr1_tick, arr_tick, spi_tick}),
            cpu_tick ? 15 : 0);
    end

    // table walk: R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      e = VEC[v];
      write_reg(1'b0, e[36:29]);
      write_reg(1'b1, e[28:21]);
      repeat (4) @(negedge clk);
      read_reg(1'b0, rd); check("R7 reg0 readback", int'(rd), int'(e[20:13]));
      read_reg(1'b1, rd); check("R7 reg1 readback", int'(rd), int'(e[12:5]));
      count_ticks(c);
      for (int k = 0; k < 5; k++)
        check("R4/R5/R6 tick count", c[k], e[4-k] ? 8 : 4);
    end

    // R3: entering double speed is deferred to the divider edge
    write_reg(1'b0, 8'h00); write_reg(1'b1, 8'h00);
    repeat (4) @(negedge clk);
    do @(negedge clk); while (!cpu_tick);
    cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h01;
    exp_pat = '{0, 1, 1, 1};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      check("R3 entry pattern", int'(cpu_tick), exp_pat[k]);
    end

    // R3: leaving double speed, phase seen through slow timer 0
    write_reg(1'b0, 8'h03);
    repeat (4) @(negedge clk);
    do @(negedge clk); while (!tmr0_tick);
    cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h02;
    exp_pat = '{1, 1, 0, 1};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      check("R3 exit pattern", int'(cpu_tick), exp_pat[k]);
    end

    // R5: slow timer 0 in double speed pulses only with the divider phase
    write_reg(1'b0, 8'h03);
    repeat (4) @(negedge clk);
    do @(negedge clk); while (!tmr0_tick);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 slow alternation", int'(tmr0_tick), k % 2);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule